// File: doc/BRIEF.md
# Rank-Coded Cell Write-Verify Controller

This controller manages a one-bit storage cell built from two resistive switching devices. The bit is held in the ordering of the two devices' conductances, never in an absolute level. An external comparator looks at the two readout levels and reports which one is higher. The controller decodes that report into a bit and a validity flag. It runs the cell through read phases and write phases. In a read phase the excitation is on and both write lines are disconnected. In a write phase the excitation is off and exactly one write line carries a pulse.

A plain read excites the cell, lets the levels settle, samples the comparator and returns the bit. A write starts with a verify read. If the cell already holds the target, the write ends with no pulse. If it does not, the controller issues one pulse and reads again, and it repeats this until the bit matches or a programmable retry limit runs out. Switching in these devices is stochastic, so one pulse may not be enough. The pulses alternate between two kinds:
- a turn-on pulse to the device that must end up more conductive;
- a turn-off pulse to the other device.

The state machine has six states: `ST_IDLE`, `ST_SETTLE`, `ST_EVAL`, `ST_PULSE`, `ST_DONE` and `ST_FAIL`. Its transitions are:
- IDLE→SETTLE when a request arrives.
- SETTLE→EVAL when the settle timer expires.
- From EVAL:
  - EVAL→DONE on a plain read or a matching bit.
  - EVAL→FAIL on a mismatch once the limit has been reached.
  - EVAL→PULSE on a mismatch with retries left.
- PULSE→SETTLE when the pulse timer expires.
- DONE→IDLE and FAIL→IDLE unconditionally.

Top module: `rcc_wv_ctrl`

## Requirements
- R1: During and straight after reset, `busy`, `done`, `err`, `pulse_en`, `exc_en`, `sample` and `rd_valid` are all low.
- R2: The comparator code decodes as follows. `2'b01` (first level below second) gives bit 0 with `rd_valid`=1. `2'b10` (first above second) gives bit 1 with `rd_valid`=1. `2'b00` and `2'b11` give `rd_valid`=0. A plain read ends with `done` and no pulse.
- R3: A read phase keeps `exc_en` high and `pulse_en` low for SETTLE_CYC+1 cycles. `sample` is high only in the last of those cycles.
- R4: While `pulse_en` is high, `exc_en` is low. Each pulse lasts exactly PULSE_CYC cycles.
- R5: Pulses are numbered from 0 within one write. An even-numbered pulse is a turn-on pulse (`pulse_off`=0) on the device `wsel`=target. An odd-numbered pulse is a turn-off pulse (`pulse_off`=1) on the device `wsel`=not target. `wsel`=0 is the first device. `wsel` and `pulse_off` do not change during a pulse.
- R6: Every pulse is followed by a verify read. A write that finishes after n pulses raises `done` SETTLE_CYC+1+n*(PULSE_CYC+SETTLE_CYC+1) cycles after the accepting edge. At that point `rd_bit` equals the target and `rd_valid`=1.
- R7: A write whose target already matches the cell finishes after one verify read and issues no pulse.
- R8: An undefined comparator code during a verify read counts as a mismatch and leads to another pulse.
- R9: If the bit still mismatches after `retry_limit` pulses, `err` is raised and no further pulse is issued. A limit of 0 raises `err` right after the first read.
- R10: Requests are accepted only in idle, and `busy` is high from acceptance until the end. Requests made while busy are ignored. If `req_valid` and `rd_req` arrive together, the write is performed.
- R11: `done` and `err` last one cycle each, never coincide, and see `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request |
| req_bit | input | 1 | Target bit of a write |
| rd_req | input | 1 | Plain read request |
| retry_limit | input | RETRY_W | Maximum pulses per write |
| cmp_code | input | 2 | Comparator result |
| exc_en | output | 1 | Readout excitation enable |
| sample | output | 1 | Comparator sample strobe |
| pulse_en | output | 1 | Route the selected write line to the pulse source |
| wsel | output | 1 | Write line select (0 first device, 1 second) |
| pulse_off | output | 1 | Turn-off amplitude select |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation completed |
| err | output | 1 | Retry limit exhausted |
| rd_bit | output | 1 | Last decoded bit |
| rd_valid | output | 1 | Last decoded bit was defined |

## Verification
Every result has a due cycle counted from the edge that accepts the request:
- A plain read raises `done` SETTLE_CYC+1 edges after acceptance.
- Each pulse adds PULSE_CYC+SETTLE_CYC+1 edges.
- `err` follows the same rule, using the limit as the number of pulses.

The bench drives inputs on falling edges. It counts falling edges from acceptance until `done` or `err` appears, and compares that count with the formula. A monitor also samples on falling edges. It checks each pulse's select, amplitude and width and the excitation level during the pulse. A behavioural cell model in the bench flips the comparator code after a chosen number of pulses.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_EVAL,
        ST_PULSE,
        ST_DONE,
        ST_FAIL
    } rcc_state_e;

    localparam logic [1:0] CMP_FIRST_LOW  = 2'b01;
    localparam logic [1:0] CMP_FIRST_HIGH = 2'b10;
endpackage

// File: rtl/rcc_decode.sv
module rcc_decode
    import rcc_pkg::*;
(
    input  logic [1:0] cmp,
    output logic       bit_o,
    output logic       valid_o
);
    always_comb begin
        unique case (cmp)
            CMP_FIRST_LOW: begin
                bit_o   = 1'b0;
                valid_o = 1'b1;
            end
            CMP_FIRST_HIGH: begin
                bit_o   = 1'b1;
                valid_o = 1'b1;
            end
            default: begin
                bit_o   = 1'b0;
                valid_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rcc_timer.sv
module rcc_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/rcc_retry.sv
module rcc_retry #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         odd,
    output logic         at_limit
);
    logic [W-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    assign odd      = count[0];
    assign at_limit = (count == limit);
endmodule

// File: rtl/rcc_wv_ctrl.sv
module rcc_wv_ctrl
    import rcc_pkg::*;
#(
    parameter int SETTLE_CYC = 4,
    parameter int PULSE_CYC  = 8,
    parameter int RETRY_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_bit,
    input  logic               rd_req,
    input  logic [RETRY_W-1:0] retry_limit,
    input  logic [1:0]         cmp_code,
    output logic               exc_en,
    output logic               sample,
    output logic               pulse_en,
    output logic               wsel,
    output logic               pulse_off,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               rd_bit,
    output logic               rd_valid
);
    localparam int TMAX = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] PULSE_LD  = TW'(PULSE_CYC - 1);

    rcc_state_e st, nxt;
    logic op_wr, tgt;
    logic ld_settle, ld_pulse, cnt_clr, cnt_inc;
    logic tmr_zero, dec_bit, dec_valid, odd_pulse, at_limit;

    rcc_decode u_dec (
        .cmp     (cmp_code),
        .bit_o   (dec_bit),
        .valid_o (dec_valid)
    );

    rcc_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_settle | ld_pulse),
        .load_val (ld_pulse ? PULSE_LD : SETTLE_LD),
        .zero     (tmr_zero)
    );

    rcc_retry #(.W(RETRY_W)) u_rty (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .limit    (retry_limit),
        .odd      (odd_pulse),
        .at_limit (at_limit)
    );

    // next-state and sequencing strobes
    always_comb begin
        nxt       = st;
        ld_settle = 1'b0;
        ld_pulse  = 1'b0;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (req_valid || rd_req) begin
                    nxt       = ST_SETTLE;
                    ld_settle = 1'b1;
                    cnt_clr   = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) nxt = ST_EVAL;
            end
            ST_EVAL: begin
                if (!op_wr || (dec_valid && dec_bit == tgt)) begin
                    nxt = ST_DONE;
                end else if (at_limit) begin
                    nxt = ST_FAIL;
                end else begin
                    nxt      = ST_PULSE;
                    ld_pulse = 1'b1;
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    nxt       = ST_SETTLE;
                    ld_settle = 1'b1;
                    cnt_inc   = 1'b1;
                end
            end
            ST_DONE, ST_FAIL: nxt = ST_IDLE;
            default:          nxt = ST_IDLE;
        endcase
    end

    // state and operation registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            op_wr    <= 1'b0;
            tgt      <= 1'b0;
            rd_bit   <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            st <= nxt;
            if (st == ST_IDLE && (req_valid || rd_req)) begin
                op_wr <= req_valid;
                tgt   <= req_bit;
            end
            if (st == ST_EVAL) begin
                rd_bit   <= dec_bit;
                rd_valid <= dec_valid;
            end
        end
    end

    // Moore outputs
    always_comb begin
        exc_en    = (st == ST_SETTLE) || (st == ST_EVAL);
        sample    = (st == ST_EVAL);
        pulse_en  = (st == ST_PULSE);
        pulse_off = (st == ST_PULSE) && odd_pulse;
        wsel      = (st == ST_PULSE) && (tgt ^ odd_pulse);
        busy      = (st == ST_SETTLE) || (st == ST_EVAL) || (st == ST_PULSE);
        done      = (st == ST_DONE);
        err       = (st == ST_FAIL);
    end
endmodule

// File: rtl/rcc_wv_chk.sv
module rcc_wv_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic rd_req,
    input logic exc_en,
    input logic sample,
    input logic pulse_en,
    input logic wsel,
    input logic pulse_off,
    input logic busy,
    input logic done,
    input logic err
);
    // R4
    excite_vs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_en && pulse_en));

    // R3
    sample_excited_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> (exc_en && !pulse_en));

    // R11
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));

    // R11
    end_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !busy);

    // R10
    pulse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_en |-> busy);

    // R10
    start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid || rd_req));

    // R5
    wsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_en && $past(pulse_en)) |-> ($stable(wsel) && $stable(pulse_off)));

    // R6
    pulse_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_en) |-> exc_en);
endmodule

bind rcc_wv_ctrl rcc_wv_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rd_req    (rd_req),
    .exc_en    (exc_en),
    .sample    (sample),
    .pulse_en  (pulse_en),
    .wsel      (wsel),
    .pulse_off (pulse_off),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/sim_rcc_wv_ctrl.sv
`timescale 1ns/1ps
module sim_rcc_wv_ctrl;
    localparam int S = 4;
    localparam int P = 8;
    localparam int NV = 8;
    localparam int NEVER = 99;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_bit = 1'b0, rd_req = 1'b0;
    logic [3:0] retry_limit = '0;
    logic [1:0] cmp_code = 2'b00;
    logic exc_en, sample, pulse_en, wsel, pulse_off, busy, done, err, rd_bit, rd_valid;

    int nvec = 0, nfail = 0;
    int pcount = 0, pw = 0, flip_at = NEVER;
    logic cur_tgt = 1'b0;
    logic prev_pe = 1'b0;

    always #5 clk = ~clk;

    rcc_wv_ctrl #(.SETTLE_CYC(S), .PULSE_CYC(P), .RETRY_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bit(req_bit),
        .rd_req(rd_req), .retry_limit(retry_limit), .cmp_code(cmp_code),
        .exc_en(exc_en), .sample(sample), .pulse_en(pulse_en), .wsel(wsel),
        .pulse_off(pulse_off), .busy(busy), .done(done), .err(err),
        .rd_bit(rd_bit), .rd_valid(rd_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // cell model and pulse monitor
    always @(negedge clk) begin
        if (pulse_en) begin
            if (!prev_pe) begin
                chk(wsel == (cur_tgt ^ pcount[0]), "R5 wsel", int'(wsel), int'(cur_tgt ^ pcount[0]));
                chk(pulse_off == pcount[0], "R5 pulse_off", int'(pulse_off), int'(pcount[0]));
                pw = 0;
                pcount++;
                if (pcount == flip_at) cmp_code = cur_tgt ? 2'b10 : 2'b01;
            end
            pw++;
            chk(!exc_en, "R4 excitation off in pulse", int'(exc_en), 0);
        end else if (prev_pe) begin
            chk(pw == P, "R4 pulse width", pw, P);
        end
        prev_pe = pulse_en;
    end

    // Vector table: target, initial code, flip after pulse, limit, exp err, exp pulses
    localparam int V_TGT [NV] = '{1, 0, 0, 1, 1, 0, 1, 0};
    localparam int V_CMP [NV] = '{2, 1, 2, 1, 1, 0, 3, 2};
    localparam int V_FLP [NV] = '{NEVER, NEVER, 1, 3, NEVER, 1, 2, NEVER};
    localparam int V_LIM [NV] = '{3, 3, 3, 3, 2, 4, 5, 0};
    localparam int V_ERR [NV] = '{0, 0, 0, 0, 1, 0, 0, 1};
    localparam int V_NP  [NV] = '{0, 0, 1, 3, 2, 1, 2, 0};

    task automatic run_op(input bit wr, input bit rd, input bit t, input logic [1:0] c0,
                          input int fl, input int lim, input int disturb_at,
                          output int cyc, output bit got_err, output int nsample);
        @(negedge clk);
        cmp_code = c0; cur_tgt = t; flip_at = fl; pcount = 0;
        retry_limit = 4'(lim); req_bit = t; req_valid = wr; rd_req = rd;
        cyc = 0; nsample = 0;
        do begin
            @(negedge clk);
            cyc++;
            req_valid = (cyc == disturb_at);
            rd_req    = (cyc == disturb_at);
            if (cyc == disturb_at) req_bit = !t;
            if (sample) nsample++;
        end while (!(done || err) && cyc < 2000);
        got_err = err;
        req_valid = 1'b0; rd_req = 1'b0;
        @(negedge clk);
        chk(!done && !err && !busy, "R11 single-cycle end", int'({done, err, busy}), 0);
    endtask

    initial begin
        #1_000_000;
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        int cyc, ns;
        bit ge;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({busy, done, err, pulse_en, exc_en, sample, rd_valid} == 7'b0, "R1 in reset",
            int'({busy, done, err, pulse_en, exc_en, sample, rd_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, err, pulse_en, exc_en, rd_valid} == 6'b0, "R1 after reset",
            int'({busy, done, err, pulse_en, exc_en, rd_valid}), 0);

        // vector table: writes (R6 R7 R8 R9)
        for (int i = 0; i < NV; i++) begin
            run_op(1'b1, 1'b0, V_TGT[i][0], V_CMP[i][1:0], V_FLP[i], V_LIM[i], 0, cyc, ge, ns);
            chk(int'(ge) == V_ERR[i], "R9 outcome", int'(ge), V_ERR[i]);
            chk(pcount == V_NP[i], "R8 pulse count", pcount, V_NP[i]);
            chk(cyc == S + 2 + V_NP[i] * (P + S + 1), "R6 latency", cyc, S + 2 + V_NP[i] * (P + S + 1));
            chk(ns == V_NP[i] + 1, "R6 verify reads", ns, V_NP[i] + 1);
            if (V_ERR[i] == 0)
                chk(rd_bit == V_TGT[i][0] && rd_valid, "R7 read bit", int'(rd_bit), V_TGT[i]);
        end

        // plain reads (R2 R3)
        run_op(1'b0, 1'b1, 1'b0, 2'b01, NEVER, 0, 0, cyc, ge, ns);
        chk(rd_bit == 1'b0 && rd_valid, "R2 read low", int'({rd_bit, rd_valid}), 1);
        chk(cyc == S + 2 && pcount == 0 && !ge, "R2 read latency", cyc, S + 2);
        chk(ns == 1, "R3 one sample", ns, 1);
        run_op(1'b0, 1'b1, 1'b0, 2'b10, NEVER, 0, 0, cyc, ge, ns);
        chk(rd_bit == 1'b1 && rd_valid, "R2 read high", int'({rd_bit, rd_valid}), 3);
        run_op(1'b0, 1'b1, 1'b1, 2'b00, NEVER, 0, 0, cyc, ge, ns);
        chk(!rd_valid, "R2 undefined 00", int'(rd_valid), 0);
        run_op(1'b0, 1'b1, 1'b1, 2'b11, NEVER, 0, 0, cyc, ge, ns);
        chk(!rd_valid, "R2 undefined 11", int'(rd_valid), 0);

        // R10 requests while busy are ignored
        run_op(1'b1, 1'b0, 1'b1, 2'b01, 1, 3, 3, cyc, ge, ns);
        chk(cyc == S + 2 + (P + S + 1) && pcount == 1 && !ge, "R10 ignore while busy", cyc, S + 2 + (P + S + 1));
        chk(rd_bit == 1'b1, "R10 target kept", int'(rd_bit), 1);
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R10 no late start", int'({busy, done}), 0);

        // R10 write wins over simultaneous read
        run_op(1'b1, 1'b1, 1'b0, 2'b10, 1, 2, 0, cyc, ge, ns);
        chk(pcount == 1 && cyc == S + 2 + (P + S + 1), "R10 write priority", pcount, 1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule